// File: doc/BRIEF.md
# Tree-Walking Huffman Symbol Decoder

This block turns a serial stream of code bits into 8-bit characters. The code tree lives in a node memory inside the block. Each node word is tagged as either a branch, which holds two child pointers, or a leaf, which holds a character. A walk pointer starts at the root. Each accepted code bit moves the pointer to one child of the current branch. When the walk lands on a leaf, the leaf's character goes out on the output stream and the pointer returns to the root.

Code bits arrive on a valid/ready stream. A separate marker beat on the same stream signals end of input. Characters leave on a second valid/ready stream. A write port fills the node memory before decoding starts. The memory has one cycle of read latency, so each step of the walk uses a fetch cycle and then a decide cycle. A one-cycle completion pulse follows the end marker once every decoded character has been taken.

Top module: `huff_walk_top`

## Requirements
- R1: A node word is 19 bits. Bit 18 is the tag: 1 means leaf and 0 means branch. In a branch, bits 17:9 hold the left child address and bits 8:0 hold the right child address. In a leaf, bits 7:0 hold the character. Every walk begins at address 0.
- R2: An accepted code bit of 0 moves the walk to the left child. A code bit of 1 moves it to the right child. A full codeword therefore yields the character of the leaf it reaches.
- R3: Reaching a leaf consumes no code bit. `in_ready` stays low while a character is pending on the output. The bit that follows a codeword starts the next codeword from the root.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_char` holds its value. The walk does not advance.
- R5: A beat with `in_valid` and `in_end` both high ends the stream, and `in_bit` is ignored on that beat. Bits of an unfinished codeword taken before the marker produce no character.
- R6: `done` rises for exactly one cycle after the end marker is accepted. Every character has already been accepted when it rises. After it, `in_ready` and `out_valid` stay low until reset.
- R7: While reset is held and right after it is released, `out_valid` and `done` are low.
- R8: A cycle with `ld_en` high writes `ld_data` to node address `ld_addr`. `in_ready` is low during that cycle, and the next decision uses a fresh read of the node memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Node memory write strobe |
| ld_addr | input | 9 | Node address to write |
| ld_data | input | 19 | Node word to write |
| in_valid | input | 1 | Input beat present |
| in_bit | input | 1 | Code bit (0 = left, 1 = right) |
| in_end | input | 1 | Beat is the end-of-stream marker |
| in_ready | output | 1 | Decoder takes the current input beat |
| out_valid | output | 1 | Decoded character present |
| out_char | output | 8 | Decoded character |
| out_ready | input | 1 | Consumer takes the character |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker assumes the input side never writes the node memory during a decode. It also assumes the loaded tree contains no cycle of branches and has a branch at the root; a leaf at the root would emit forever without taking a bit. The bench loads each tree and then pulses reset before streaming, so no write falls inside a walk. Both trees it uses are acyclic and have a branch at the root. The bench sweeps every codeword of a balanced eight-leaf tree and of an unbalanced six-leaf tree whose nodes sit at scattered high addresses. It computes the expected characters from the codeword arithmetic and applies a periodic stall pattern on the output.

// File: rtl/huff_pkg.sv
package huff_pkg;

    // Walker phases: fetch a node, decide on it, hold a character, halted.
    typedef enum logic [1:0] {
        WK_FETCH  = 2'd0,
        WK_DECIDE = 2'd1,
        WK_EMIT   = 2'd2,
        WK_HALT   = 2'd3
    } walk_st_e;

endpackage

// File: rtl/huff_node_ram.sv
module huff_node_ram #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 19
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] rd_q;

    // Synchronous write; read data is registered and held between reads.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/huff_node_dec.sv
module huff_node_dec #(
    parameter int PTR_W  = 9,
    parameter int CHAR_W = 8
) (
    input  logic [2*PTR_W:0]  node,
    output logic              is_leaf,
    output logic [PTR_W-1:0]  left,
    output logic [PTR_W-1:0]  right,
    output logic [CHAR_W-1:0] chr
);
    localparam int TAG_BIT = 2 * PTR_W;

    // Tag in the top bit; branch pointers fill the rest, leaf char at the bottom.
    always_comb begin
        is_leaf = node[TAG_BIT];
        left    = node[TAG_BIT-1:PTR_W];
        right   = node[PTR_W-1:0];
        chr     = node[CHAR_W-1:0];
    end

endmodule

// File: rtl/huff_walk_ctrl.sv
module huff_walk_ctrl
    import huff_pkg::*;
#(
    parameter int PTR_W  = 9,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_busy,
    input  logic              node_leaf,
    input  logic [PTR_W-1:0]  node_left,
    input  logic [PTR_W-1:0]  node_right,
    input  logic [CHAR_W-1:0] node_chr,
    output logic              rd_en,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic              in_valid,
    input  logic              in_bit,
    input  logic              in_end,
    output logic              in_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    input  logic              out_ready,
    output logic              done
);
    localparam logic [PTR_W-1:0] ROOT = '0;

    typedef struct packed {
        walk_st_e          st;
        logic [PTR_W-1:0]  ptr;
        logic [CHAR_W-1:0] chr;
        logic              done;
    } walk_t;

    localparam walk_t WALK_RST = '{st: WK_FETCH, ptr: ROOT, chr: '0, done: 1'b0};

    walk_t walk_d, walk_q;

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        rd_en       = 1'b0;
        rd_addr     = walk_q.ptr;
        in_ready    = 1'b0;
        unique case (walk_q.st)
            WK_FETCH: begin
                if (!ld_busy) begin
                    rd_en     = 1'b1;
                    walk_d.st = WK_DECIDE;
                end
            end
            WK_DECIDE: begin
                if (ld_busy) begin
                    // Memory may change under us: re-read after the load.
                    walk_d.st = WK_FETCH;
                end else if (node_leaf) begin
                    walk_d.chr = node_chr;
                    walk_d.st  = WK_EMIT;
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        if (in_end) begin
                            walk_d.st   = WK_HALT;
                            walk_d.done = 1'b1;
                        end else begin
                            walk_d.ptr = in_bit ? node_right : node_left;
                            walk_d.st  = WK_FETCH;
                        end
                    end
                end
            end
            WK_EMIT: begin
                if (out_ready) begin
                    walk_d.ptr = ROOT;
                    walk_d.st  = WK_FETCH;
                end
            end
            WK_HALT: begin
            end
            default: walk_d = WALK_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= WALK_RST;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign out_valid = (walk_q.st == WK_EMIT);
    assign out_char  = walk_q.chr;
    assign done      = walk_q.done;

endmodule

// File: rtl/huff_walk_top.sv
module huff_walk_top #(
    parameter int PTR_W  = 9,
    parameter int CHAR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_en,
    input  logic [PTR_W-1:0]    ld_addr,
    input  logic [2*PTR_W:0]    ld_data,
    input  logic                in_valid,
    input  logic                in_bit,
    input  logic                in_end,
    output logic                in_ready,
    output logic                out_valid,
    output logic [CHAR_W-1:0]   out_char,
    input  logic                out_ready,
    output logic                done
);
    localparam int NODE_W = 2 * PTR_W + 1;

    logic [NODE_W-1:0] node_word;
    logic              rd_en;
    logic [PTR_W-1:0]  rd_addr;
    logic              node_leaf;
    logic [PTR_W-1:0]  node_left;
    logic [PTR_W-1:0]  node_right;
    logic [CHAR_W-1:0] node_chr;

    huff_node_ram #(.ADDR_W(PTR_W), .WORD_W(NODE_W)) u_ram (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (node_word)
    );

    huff_node_dec #(.PTR_W(PTR_W), .CHAR_W(CHAR_W)) u_dec (
        .node    (node_word),
        .is_leaf (node_leaf),
        .left    (node_left),
        .right   (node_right),
        .chr     (node_chr)
    );

    huff_walk_ctrl #(.PTR_W(PTR_W), .CHAR_W(CHAR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_busy    (ld_en),
        .node_leaf  (node_leaf),
        .node_left  (node_left),
        .node_right (node_right),
        .node_chr   (node_chr),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .in_end     (in_end),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_char   (out_char),
        .out_ready  (out_ready),
        .done       (done)
    );

endmodule

// File: rtl/huff_walk_chk.sv
module huff_walk_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic              in_ready,
    input logic              out_valid,
    input logic [CHAR_W-1:0] out_char,
    input logic              out_ready,
    input logic              done
);
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_char));

    // R3
    no_bit_at_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !in_ready && !out_valid);

    // R6
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !in_ready);

    // R8
    load_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !in_ready);

endmodule

bind huff_walk_top huff_walk_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_char  (out_char),
    .out_ready (out_ready),
    .done      (done)
);

// File: tb/huff_walk_top_tb.sv
`timescale 1ns/1ps
module huff_walk_top_tb;
    localparam int PTR_W  = 9;
    localparam int CHAR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en = 1'b0;
    logic [PTR_W-1:0]  ld_addr = '0;
    logic [2*PTR_W:0]  ld_data = '0;
    logic              in_valid = 1'b0;
    logic              in_bit = 1'b0;
    logic              in_end = 1'b0;
    logic              in_ready;
    logic              out_valid;
    logic [CHAR_W-1:0] out_char;
    logic              out_ready = 1'b0;
    logic              done;

    huff_walk_top #(.PTR_W(PTR_W), .CHAR_W(CHAR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .in_valid(in_valid), .in_bit(in_bit), .in_end(in_end), .in_ready(in_ready),
        .out_valid(out_valid), .out_char(out_char), .out_ready(out_ready), .done(done)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    logic       bit_arr [0:511];
    logic [7:0] exp_arr [0:127];
    int nbits;
    int nexp;
    int got;

    always @(negedge clk) if (done) done_cnt++;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_node(input int addr, input logic [2*PTR_W:0] word);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = PTR_W'(addr);
        ld_data = word;
        #1;
        chk(in_ready == 1'b0, "R8 in_ready during load", int'(in_ready), 0);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Drive nbits code bits then an end marker; collect characters with optional stall.
    task automatic run_stream(input logic stall);
        int dbefore;
        got = 0;
        dbefore = done_cnt;
        fork
            begin
                for (int i = 0; i <= nbits; i++) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_end   = (i == nbits);
                    in_bit   = (i == nbits) ? 1'b1 : bit_arr[i];
                    #1;
                    while (!in_ready) begin
                        @(negedge clk);
                        #1;
                    end
                end
                @(negedge clk);
                in_valid = 1'b0;
                in_end   = 1'b0;
            end
            begin
                int rc;
                int tail;
                logic stalled;
                logic [7:0] held;
                rc = 0; tail = 0; stalled = 1'b0; held = '0;
                while (tail < 6) begin
                    @(negedge clk);
                    out_ready = stall ? ((rc % 3) != 0) : 1'b1;
                    rc++;
                    #1;
                    if (done_cnt != dbefore) begin
                        if (tail == 0)
                            chk(got == nexp, "R6 all chars taken before done", got, nexp);
                        tail++;
                    end
                    if (out_valid) begin
                        chk(!in_ready, "R3 input held while char pending", int'(in_ready), 0);
                        if (stalled)
                            chk(out_char == held, "R4 char stable under stall", int'(out_char), int'(held));
                        if (out_ready) begin
                            if (got < nexp)
                                chk(out_char == exp_arr[got], "R2 decoded char", int'(out_char), int'(exp_arr[got]));
                            else
                                chk(1'b0, "R5 extra char", int'(out_char), 0);
                            got++;
                            stalled = 1'b0;
                        end else begin
                            stalled = 1'b1;
                            held    = out_char;
                        end
                    end
                end
                out_ready = 1'b0;
            end
        join
        chk(got == nexp, "R5 char count", got, nexp);
        chk(done_cnt - dbefore == 1, "R6 one done pulse", done_cnt - dbefore, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Tree A: balanced heap of depth 3, leaf k has code = k (MSB first), char 0x40+k.
        do_reset();
        for (int i = 0; i < 7; i++)
            load_node(i, {1'b0, PTR_W'(2*i+1), PTR_W'(2*i+2)});
        for (int i = 7; i < 15; i++)
            load_node(i, {1'b1, 10'd0, 8'(8'h40 + i - 7)});
        do_reset();
        #1;
        // R7 reset state
        chk(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
        chk(done == 1'b0, "R7 done after reset", int'(done), 0);

        // R1 R2: every codeword forwards, then backwards
        nbits = 0; nexp = 0;
        for (int n = 0; n < 16; n++) begin
            int k;
            k = (n < 8) ? n : 15 - n;
            for (int b = 2; b >= 0; b--) begin
                bit_arr[nbits] = 1'((k >> b) & 1);
                nbits++;
            end
            exp_arr[nexp] = 8'(8'h40 + k);
            nexp++;
        end
        run_stream(1'b0);

        // Tree B: unbalanced; symbol s<5 = s ones then 0, symbol 5 = five ones; char 0xF0+s.
        do_reset();
        for (int j = 0; j < 5; j++) begin
            int baddr;
            int laddr;
            int raddr;
            baddr = (j == 0) ? 0 : 300 + j;
            laddr = 400 + j;
            raddr = (j < 4) ? 301 + j : 511;
            load_node(baddr, {1'b0, PTR_W'(laddr), PTR_W'(raddr)});
        end
        for (int s = 0; s < 6; s++)
            load_node((s == 5) ? 511 : 400 + s, {1'b1, 10'd0, 8'(8'hF0 + s)});
        do_reset();

        // R1 R3 R4 R5: mixed symbols with backpressure, then a partial codeword
        nbits = 0; nexp = 0;
        for (int n = 0; n < 24; n++) begin
            int s;
            s = (n * 5) % 6;
            for (int b = 0; b < s; b++) begin
                bit_arr[nbits] = 1'b1;
                nbits++;
            end
            if (s < 5) begin
                bit_arr[nbits] = 1'b0;
                nbits++;
            end
            exp_arr[nexp] = 8'(8'hF0 + s);
            nexp++;
        end
        bit_arr[nbits] = 1'b1; nbits++;
        bit_arr[nbits] = 1'b1; nbits++;
        run_stream(1'b1);

        // R5 R6: empty stream
        do_reset();
        nbits = 0; nexp = 0;
        run_stream(1'b0);

        // R6: halted state holds after done
        repeat (5) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R6 in_ready after done", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R6 out_valid after done", int'(out_valid), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule